// File: doc/BRIEF.md
# Match-Compare System Timer with Watchdog

This block is a general-purpose system timer for a processor subsystem. A free-running up-counter advances once for every cycle in which the `tick` input is high, and it rolls over from all-ones to zero. Four compare channels each hold a software-programmed value. When the counter equals a channel's value on a counting cycle and that channel is enabled, the channel latches a status flag. The flag drives one interrupt request line toward an external interrupt controller.

Compare channel 3 can also serve as a watchdog. Software arms the watchdog once. From then on, if the counter reaches the channel 3 value, the block drives a processor reset output for a fixed number of clock cycles. To keep the system alive, software reads the counter, adds a margin and writes the sum back to channel 3. Matching therefore uses plain equality, so a deadline that lies past the counter's rollover point still fires at the right count.

All state is reached through a simple word-addressed register bus with byte addresses. Reads are combinational. Writes take effect at the clock edge.

Top module: `match_timer`

## Requirements
- R1: On each clock edge with `tick` high and no counter write, the counter increases by one, and it wraps from 0xFFFFFFFF to 0. With `tick` low it holds.
- R2: Compare values for channels 0 to 3 are readable and writable at byte addresses 0x00, 0x04, 0x08 and 0x0C. The counter is readable and writable at 0x10.
- R3: When bit i of the enable register (0x1C, bits 3:0) is set and the counter equals compare value i on a counting cycle, bit i of the status register (0x14) becomes 1 at that edge. `irq[i]` equals status bit i.
- R4: A channel whose enable bit is 0 never sets its status bit on a match.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A match on the same edge as a clear leaves the bit set.
- R6: Bit 0 of the watchdog arm register (0x18) is set by writing 1, reads back as bit 0, and cannot be cleared by any bus write. Only `rst` clears it.
- R7: While the watchdog is armed, a channel 3 match raises `wdog_rst` on the next edge and holds it high for exactly 256 clock cycles, whatever the channel 3 enable bit is.
- R8: In a cycle where the counter is written, no channel compares, even with `tick` high.
- R9: Addresses other than the eight listed registers read as zero.
- R10: A compare value reached only after the counter wraps past all-ones still produces its match.
- R11: After `rst` the counter, compare values, status, enables and arm bit are all zero and `wdog_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance strobe |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 4 | Per-channel interrupt request, one per status bit |
| wdog_rst | output | 1 | Watchdog reset pulse toward the processor |

## Verification
The assertions assume that `rst` is held high for at least one edge before other inputs matter. They also assume that `bus_addr` and `bus_we` are stable around the clock edge, so each write lands at exactly one edge. The bench changes every input on the falling edge and releases the write strobe one cycle after raising it. It sets up compare values while `tick` is low, so only the intended ticks can match. It arms the watchdog last and moves channel 3 well away from the counter before the remaining activity, so no stray watchdog pulse can disturb the other checks.

// File: rtl/mt_pkg.sv
package mt_pkg;

    localparam int unsigned ADDR_W = 6;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t ADR_CNT  = 6'h10;
    localparam addr_t ADR_STAT = 6'h14;
    localparam addr_t ADR_ARM  = 6'h18;
    localparam addr_t ADR_IE   = 6'h1C;

    typedef struct packed {
        logic  we;
        addr_t addr;
    } bus_ctl_t;

    function automatic addr_t chan_addr(input int unsigned ch);
        return addr_t'(ch * 4);
    endfunction

endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         cmp_en
);
    assign cmp_en = tick & ~ld;

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (ld)     cnt <= ld_val;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && cnt == {W{1'b1}}) |=> (cnt == '0));

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld) |=> $stable(cnt));

endmodule

// File: rtl/mt_match_chan.sv
module mt_match_chan #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp_en,
    input  logic [W-1:0] cnt,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    input  logic         ie,
    output logic [W-1:0] value,
    output logic         hit,
    output logic         status
);
    logic set;

    assign hit = cmp_en && (cnt == value);
    assign set = hit && ie;

    always_ff @(posedge clk) begin
        if (rst)     value <= '0;
        else if (wr) value <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)      status <= 1'b0;
        else if (set) status <= 1'b1;
        else if (clr) status <= 1'b0;
    end

    p_set_r3: assert property (@(posedge clk) disable iff (rst)
        (hit && ie) |=> status);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !status);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (status && !clr) |=> status);

    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!ie && !status) |=> !status);

endmodule

// File: rtl/mt_wdog.sv
module mt_wdog #(
    parameter int unsigned PULSE_LEN = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_set,
    input  logic trig,
    output logic armed,
    output logic pulse
);
    localparam int unsigned CW = $clog2(PULSE_LEN + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)          armed <= 1'b0;
        else if (arm_set) armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                          left <= '0;
        else if (left != '0)              left <= left - 1'b1;
        else if (trig && armed)           left <= CW'(PULSE_LEN);
    end

    assign pulse = (left != '0);

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);

    p_fire_r7: assert property (@(posedge clk) disable iff (rst)
        (trig && armed && !pulse) |=> pulse);

    p_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(trig && armed));

endmodule

// File: rtl/match_timer.sv
module match_timer #(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned WDOG_CH   = 3,
    parameter int unsigned PULSE_LEN = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  bus_we,
    input  logic [5:0]            bus_addr,
    input  logic [CNT_W-1:0]      bus_wdata,
    output logic [CNT_W-1:0]      bus_rdata,
    output logic [NUM_CH-1:0]     irq,
    output logic                  wdog_rst
);
    import mt_pkg::*;

    bus_ctl_t          ctl;
    logic [CNT_W-1:0]  cnt;
    logic              cmp_en;
    logic [NUM_CH-1:0] ie_q;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] status;
    logic [CNT_W-1:0]  value [NUM_CH];
    logic              armed;

    assign ctl.we   = bus_we;
    assign ctl.addr = bus_addr;

    mt_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .ld     (ctl.we && ctl.addr == ADR_CNT),
        .ld_val (bus_wdata),
        .cnt    (cnt),
        .cmp_en (cmp_en)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        mt_match_chan #(.W(CNT_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .cmp_en (cmp_en),
            .cnt    (cnt),
            .wr     (ctl.we && ctl.addr == chan_addr(g)),
            .wdata  (bus_wdata),
            .clr    (ctl.we && ctl.addr == ADR_STAT && bus_wdata[g]),
            .ie     (ie_q[g]),
            .value  (value[g]),
            .hit    (hit[g]),
            .status (status[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                              ie_q <= '0;
        else if (ctl.we && ctl.addr == ADR_IE) ie_q <= bus_wdata[NUM_CH-1:0];
    end

    mt_wdog #(.PULSE_LEN(PULSE_LEN)) u_wd (
        .clk     (clk),
        .rst     (rst),
        .arm_set (ctl.we && ctl.addr == ADR_ARM && bus_wdata[0]),
        .trig    (hit[WDOG_CH]),
        .armed   (armed),
        .pulse   (wdog_rst)
    );

    assign irq = status;

    always_comb begin
        bus_rdata = '0;
        for (int unsigned c = 0; c < NUM_CH; c++)
            if (ctl.addr == chan_addr(c)) bus_rdata = value[c];
        case (ctl.addr)
            ADR_CNT:  bus_rdata = cnt;
            ADR_STAT: bus_rdata = CNT_W'(status);
            ADR_ARM:  bus_rdata = CNT_W'(armed);
            ADR_IE:   bus_rdata = CNT_W'(ie_q);
            default:  ;
        endcase
    end

    p_nocmp_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADR_CNT) |-> (hit == '0));

endmodule

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        wdog_rst;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    match_timer dut_i (
        .clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wdog_rst(wdog_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_tick(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        int hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state of every register and output
        for (int a = 0; a < 8; a++) begin
            rd(6'(a * 4), d);
            chk("R11", d, 32'h0);
        end
        chk("R11 irq", 32'(irq), 32'h0);
        chk("R11 wdog", 32'(wdog_rst), 32'h0);

        // R2: compare values read and write, several patterns
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 4; c++) wr(6'(c * 4), 32'hA5A5_0000 ^ (32'(c) << (8 * p)) ^ 32'(p));
            for (int c = 0; c < 4; c++) begin
                rd(6'(c * 4), d);
                chk("R2", d, 32'hA5A5_0000 ^ (32'(c) << (8 * p)) ^ 32'(p));
            end
        end
        wr(6'h10, 32'h1234_5678);
        rd(6'h10, d);
        chk("R2 counter", d, 32'h1234_5678);

        // R1: counting and wrap
        for (int n = 1; n <= 5; n++) begin
            wr(6'h10, 32'hFFFF_FFFE);
            ticks(n);
            rd(6'h10, d);
            chk("R1", d, 32'hFFFF_FFFE + 32'(n));
        end
        ticks(0);
        rd(6'h10, d);
        chk("R1 hold", d, 32'h3);

        // R9: unmapped addresses read zero
        for (int a = 32; a < 64; a++) begin
            rd(6'(a), d);
            chk("R9", d, 32'h0);
        end

        // R3: each enabled channel sets its own status and irq
        wr(6'h1C, 32'h7);
        for (int c = 0; c < 3; c++) begin
            wr(6'(c * 4), 32'd100 + 32'(c) * 1000);
            wr(6'h10, 32'd95 + 32'(c) * 1000);
            ticks(10);
            rd(6'h14, d);
            chk("R3 status", d, 32'(1) << c);
            chk("R3 irq", 32'(irq), 32'(1) << c);
            wr(6'h14, 32'hF);
        end

        // R4: disabled channel never flags
        wr(6'h1C, 32'h0);
        wr(6'h0, 32'd50);
        wr(6'h10, 32'd45);
        ticks(10);
        rd(6'h14, d);
        chk("R4", d, 32'h0);

        // R5: write one clears, write zero keeps, match beats clear
        wr(6'h1C, 32'h1);
        wr(6'h10, 32'd45);
        ticks(10);
        wr(6'h14, 32'h0);
        rd(6'h14, d);
        chk("R5 zero write", d, 32'h1);
        wr(6'h14, 32'h1);
        rd(6'h14, d);
        chk("R5 clear", d, 32'h0);
        wr(6'h10, 32'd50);
        wr(6'h14, 32'h1);
        wr_tick(6'h14, 32'h1);
        rd(6'h14, d);
        chk("R5 collision", d, 32'h1);
        wr(6'h14, 32'hF);

        // R8: counter write cycle does not compare
        wr(6'h10, 32'd50);
        wr_tick(6'h10, 32'd200);
        ticks(5);
        rd(6'h14, d);
        chk("R8", d, 32'h0);
        rd(6'h10, d);
        chk("R8 counter", d, 32'd205);

        // R10: match past rollover on channel 1
        wr(6'h1C, 32'h2);
        wr(6'h04, 32'h0000_0005);
        wr(6'h10, 32'hFFFF_FFF0);
        ticks(32);
        rd(6'h14, d);
        chk("R10", d, 32'h2);
        wr(6'h14, 32'hF);

        // R6: arm bit sticky
        wr(6'h1C, 32'h0);
        wr(6'h0C, 32'hFFFF_0000);
        wr(6'h18, 32'h1);
        wr(6'h18, 32'h0);
        rd(6'h18, d);
        chk("R6", d, 32'h1);

        // R7: watchdog pulse length with channel 3 interrupt disabled
        wr(6'h0C, 32'd1010);
        wr(6'h10, 32'd1000);
        hi = 0;
        @(negedge clk);
        tick = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (wdog_rst) hi++;
        end
        tick = 1'b0;
        chk("R7 length", 32'(hi), 32'd256);
        chk("R7 irq3", 32'(irq), 32'h0);
        chk("R7 end", 32'(wdog_rst), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule